// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block is the interrupt front end of a small microcontroller core. Six request sources feed it: two external event inputs, overflow pulses from two timers, a UART event, and one combined source. The combined source gathers a third timer overflow, a real-time-clock tick and a time-base overflow. Each source event sets a request flag. The flag stays set until the core services the request or software rewrites it. A master enable and six per-source enables decide which pending flags may interrupt the core.

The highest-priority pending and enabled flag wins. The block then raises a registered interrupt request with a fixed vector address. The core answers with an acknowledge. On acknowledge, the block clears the winning main flag and the master enable, so that no nested interrupt can be taken. The three sub-flags of the combined source are never cleared by hardware, and software must clear them itself.

A small state machine drives the request. It has two states:
- `ST_IDLE`: no request is shown to the core. The transition *raise* goes to `ST_PEND` when any flag is pending and enabled.
- `ST_PEND`: the request is shown. The transition *retarget* stays in `ST_PEND` and follows a new winner. The transition *grant* returns to `ST_IDLE` on acknowledge. The transition *withdraw* returns to `ST_IDLE` when nothing is pending and enabled any more.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, every flag, enable, sub-flag and sub-enable and the master enable read 0, `irq_req` is 0 and `irq_vec` is 0x00.
- R2: An event on a main source input sets that source's flag one clock edge later, whether or not the source is enabled. Main flag bit i is source i. The sources, from bit 0 to bit 5, are: ext0, ext1, tmr0, tmr1, uart, combined.
- R3: `irq_req` rises two clock edges after a flag becomes pending while the master enable and the source enable are both set. `irq_req` stays 0 while the master enable is 0 or the source enable is 0.
- R4: Bit 0 has the highest priority. While `irq_req` is 1, `irq_vec` equals 0x04 × (winning index + 1), which gives 0x04, 0x08, 0x0C, 0x10, 0x14 and 0x18. While `irq_req` is 0, `irq_vec` is 0x00.
- R5: An acknowledge while `irq_req` is 1 clears the granted main flag and the master enable at that edge, and `irq_req` is 0 from that edge on. An acknowledge while `irq_req` is 0 has no effect.
- R6: A register write replaces the written flags. If a hardware event hits the same flag in the same cycle, the flag ends set.
- R7: A sub-source event always sets its sub-flag. It also sets the combined main flag (bit 5) only if the sub-enable of that sub-source is set.
- R8: Sub-flags are cleared only by a register write. An acknowledge of the combined source leaves them unchanged.
- R9: If the pending request loses its flag or its enable before it is acknowledged, `irq_req` falls one edge after that change takes effect.
- R10: `reg_rdata` is combinational on `reg_sel`. The selections are:
  - sel 0, control register: bit 0 is the master enable and bits 1..6 are the source enables for sources 0..5.
  - sel 1, flag register: bits 0..5 are the main flags.
  - sel 2, combined-source register: bits 0..2 are the sub-enables. The sub-flags are at bit 4 (timer 2), bit 5 (time base) and bit 6 (RTC), and the sub-enables at bits 0..2 follow the same sub-source order.
  - Unused bits and sel 3 read 0.
  
  Writes use the same layout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext0_evt | input | 1 | External event 0, priority 1 |
| ext1_evt | input | 1 | External event 1, priority 2 |
| tmr0_ovf | input | 1 | Timer 0 overflow pulse, priority 3 |
| tmr1_ovf | input | 1 | Timer 1 overflow pulse, priority 4 |
| uart_evt | input | 1 | UART event, priority 5 |
| tmr2_ovf | input | 1 | Timer 2 overflow, sub-source of the combined source |
| rtc_tick | input | 1 | Real-time-clock tick, sub-source |
| tbase_ovf | input | 1 | Time-base overflow, sub-source |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| irq_ack | input | 1 | Acknowledge from the core |
| irq_req | output | 1 | Registered interrupt request |
| irq_vec | output | 8 | Vector address of the granted source |

## Verification
A main-source event is visible in the flag register one edge after it is sampled, and it reaches `irq_req` and `irq_vec` one edge later. A register write shows up in `reg_rdata` right after its edge and affects the request one edge after that. An acknowledge clears the granted flag, the master enable and `irq_req` at its own edge. The bench keeps a cycle model that it advances at each rising edge from the inputs driven during that cycle. It compares all three outputs 1 ns after that edge, so every result is checked at the cycle the timings above put it in. The directed cases repeat these counts for each requirement.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int N_SRC = 6;
    localparam int N_SUB = 3;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        SEL_CTL  = 2'd0,
        SEL_FLG  = 2'd1,
        SEL_MFC  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] hw_set,
    input  logic [N-1:0] ack_clr,
    input  logic         flg_wr,
    input  logic [N-1:0] flg_val,
    input  logic         ctl_wr,
    input  logic [N-1:0] en_val,
    input  logic         master_val,
    input  logic         master_clr,
    output logic [N-1:0] flg,
    output logic [N-1:0] en,
    output logic         master
);

    // Per-source flag and enable cells
    for (genvar i = 0; i < N; i++) begin : g_cell
        // flag: hardware set beats acknowledge clear beats software write
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                flg[i] <= 1'b0;
            else if (hw_set[i])
                flg[i] <= 1'b1;
            else if (ack_clr[i])
                flg[i] <= 1'b0;
            else if (flg_wr)
                flg[i] <= flg_val[i];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                en[i] <= 1'b0;
            else if (ctl_wr)
                en[i] <= en_val[i];
        end
    end

    // Master enable: acknowledge clear wins over a write in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            master <= 1'b0;
        else if (master_clr)
            master <= 1'b0;
        else if (ctl_wr)
            master <= master_val;
    end

endmodule

// File: rtl/irq_mf_merge.sv
module irq_mf_merge #(
    parameter int N_SUB = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SUB-1:0] sub_evt,
    input  logic             mfc_wr,
    input  logic [N_SUB-1:0] sen_val,
    input  logic [N_SUB-1:0] sflg_val,
    output logic [N_SUB-1:0] sub_en,
    output logic [N_SUB-1:0] sub_flg,
    output logic             mf_set
);

    for (genvar j = 0; j < N_SUB; j++) begin : g_sub
        // sub-flag: only a sub-event or a software write changes it
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sub_flg[j] <= 1'b0;
            else if (sub_evt[j])
                sub_flg[j] <= 1'b1;
            else if (mfc_wr)
                sub_flg[j] <= sflg_val[j];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                sub_en[j] <= 1'b0;
            else if (mfc_wr)
                sub_en[j] <= sen_val[j];
        end
    end

    // An enabled sub-event raises the combined main flag
    assign mf_set = |(sub_evt & sub_en);

endmodule

// File: rtl/irq_prio_arb.sv
module irq_prio_arb #(
    parameter int N     = 6,
    parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]     req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);

    // Lowest index wins: scan downward so the last hit is the lowest
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
    import irq_pkg::*;
#(
    parameter int DW       = 8,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 4,
    parameter int VEC_STEP = 4,
    parameter int MF_LSB   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext0_evt,
    input  logic             ext1_evt,
    input  logic             tmr0_ovf,
    input  logic             tmr1_ovf,
    input  logic             uart_evt,
    input  logic             tmr2_ovf,
    input  logic             rtc_tick,
    input  logic             tbase_ovf,
    input  logic [1:0]       reg_sel,
    input  logic             reg_wr,
    input  logic [DW-1:0]    reg_wdata,
    output logic [DW-1:0]    reg_rdata,
    input  logic             irq_ack,
    output logic             irq_req,
    output logic [VEC_W-1:0] irq_vec
);

    localparam int N     = N_SRC;
    localparam int IDX_W = $clog2(N_SRC);

    logic [N-1:0]     hw_set, flg, en, pend, ack_clr;
    logic [N_SUB-1:0] sub_evt, sub_en, sub_flg;
    logic             master_q, mf_set, any_pend, ack_fire;
    logic             ctl_wr, flg_wr, mfc_wr;
    logic [IDX_W-1:0] win_idx, gidx_q, gidx_d;
    irq_state_e       state_q, state_d;
    logic             unused_wbits;

    assign unused_wbits = ^{reg_wdata[DW-1], reg_wdata[MF_LSB-1]};

    // Sub-source order sets the sub-flag bit positions 4, 5, 6
    assign sub_evt = {rtc_tick, tbase_ovf, tmr2_ovf};
    assign hw_set  = {mf_set, uart_evt, tmr1_ovf, tmr0_ovf, ext1_evt, ext0_evt};

    assign ctl_wr = reg_wr && (reg_sel == SEL_CTL);
    assign flg_wr = reg_wr && (reg_sel == SEL_FLG);
    assign mfc_wr = reg_wr && (reg_sel == SEL_MFC);

    assign ack_fire = irq_ack && (state_q == ST_PEND);
    assign ack_clr  = ack_fire ? (N'(1) << gidx_q) : '0;

    irq_mf_merge #(.N_SUB(N_SUB)) u_mf (
        .clk      (clk),
        .rst_n    (rst_n),
        .sub_evt  (sub_evt),
        .mfc_wr   (mfc_wr),
        .sen_val  (reg_wdata[N_SUB-1:0]),
        .sflg_val (reg_wdata[MF_LSB +: N_SUB]),
        .sub_en   (sub_en),
        .sub_flg  (sub_flg),
        .mf_set   (mf_set)
    );

    irq_flag_bank #(.N(N)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_set     (hw_set),
        .ack_clr    (ack_clr),
        .flg_wr     (flg_wr),
        .flg_val    (reg_wdata[N-1:0]),
        .ctl_wr     (ctl_wr),
        .en_val     (reg_wdata[1 +: N]),
        .master_val (reg_wdata[0]),
        .master_clr (ack_fire),
        .flg        (flg),
        .en         (en),
        .master     (master_q)
    );

    assign pend = flg & en & {N{master_q}};

    irq_prio_arb #(.N(N), .IDX_W(IDX_W)) u_arb (
        .req (pend),
        .any (any_pend),
        .idx (win_idx)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            gidx_q  <= '0;
        end else begin
            state_q <= state_d;
            gidx_q  <= gidx_d;
        end
    end

    // Transitions: raise, retarget, grant, withdraw
    always_comb begin
        state_d = state_q;
        gidx_d  = gidx_q;
        unique case (state_q)
            ST_IDLE: begin
                if (any_pend) begin
                    state_d = ST_PEND;
                    gidx_d  = win_idx;
                end
            end
            ST_PEND: begin
                if (irq_ack)
                    state_d = ST_IDLE;
                else if (!any_pend)
                    state_d = ST_IDLE;
                else
                    gidx_d = win_idx;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs, all from registered state
    always_comb begin
        irq_req = (state_q == ST_PEND);
        irq_vec = '0;
        if (state_q == ST_PEND)
            irq_vec = VEC_W'(VEC_BASE) + VEC_W'(VEC_STEP) * VEC_W'(gidx_q);
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_CTL: begin
                reg_rdata[0]     = master_q;
                reg_rdata[1 +: N] = en;
            end
            SEL_FLG: reg_rdata[N-1:0] = flg;
            SEL_MFC: begin
                reg_rdata[N_SUB-1:0]      = sub_en;
                reg_rdata[MF_LSB +: N_SUB] = sub_flg;
            end
            default: reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
    parameter int N_SRC = 6,
    parameter int N_SUB = 3,
    parameter int VEC_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_ack,
    input logic             irq_req,
    input logic [VEC_W-1:0] irq_vec,
    input logic             master_q,
    input logic [N_SUB-1:0] sub_flg,
    input logic             mfc_wr,
    input logic             ext0_evt,
    input logic [N_SRC-1:0] flg
);

    // R3: a request is only raised from a set master enable
    a_r3_req_needs_master: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> $past(master_q));

    // R4: vector lies on the 4-byte grid from 0x04 to 0x18
    a_r4_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[1:0] == 2'b00 && irq_vec >= VEC_W'(4) && irq_vec <= VEC_W'(24)));

    // R5: acknowledge drops the request at its edge
    a_r5_ack_drops_req: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !irq_req);

    // R5: acknowledge clears the master enable
    a_r5_ack_clears_master: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req) |=> !master_q);

    // R6: a hardware event always leaves its flag set
    a_r6_hw_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ext0_evt |=> flg[0]);

    // R8: acknowledge never clears a sub-flag
    a_r8_subflag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_req && !mfc_wr) |=> ((sub_flg & $past(sub_flg)) == $past(sub_flg)));

endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
    .N_SRC (6),
    .N_SUB (3),
    .VEC_W (8)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_ack  (irq_ack),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .master_q (master_q),
    .sub_flg  (sub_flg),
    .mfc_wr   (mfc_wr),
    .ext0_evt (ext0_evt),
    .flg      (flg)
);

// File: tb/sim_irq_vec_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vec_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] b_evt = '0;
    logic [2:0] b_sub = '0;
    logic [1:0] b_sel = '0;
    logic       b_wr = 1'b0;
    logic [7:0] b_wdata = '0;
    logic       b_ack = 1'b0;
    logic [7:0] reg_rdata, irq_vec;
    logic       irq_req;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    // model state
    logic       m_master = 0;
    logic [5:0] m_en = 0, m_flg = 0;
    logic [2:0] m_sen = 0, m_sflg = 0;
    logic       m_req = 0;
    int         m_gidx = 0;

    always #2.5 clk = ~clk;

    irq_vec_ctrl u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext0_evt  (b_evt[0]),
        .ext1_evt  (b_evt[1]),
        .tmr0_ovf  (b_evt[2]),
        .tmr1_ovf  (b_evt[3]),
        .uart_evt  (b_evt[4]),
        .tmr2_ovf  (b_sub[0]),
        .rtc_tick  (b_sub[2]),
        .tbase_ovf (b_sub[1]),
        .reg_sel   (b_sel),
        .reg_wr    (b_wr),
        .reg_wdata (b_wdata),
        .reg_rdata (reg_rdata),
        .irq_ack   (b_ack),
        .irq_req   (irq_req),
        .irq_vec   (irq_vec)
    );

    function automatic int winner(input logic [5:0] p);
        for (int i = 5; i >= 0; i--) if (p[i]) winner = i;
        if (p == 0) winner = -1;
    endfunction

    function automatic logic [7:0] m_rd(input logic [1:0] s);
        case (s)
            2'd0: m_rd = {1'b0, m_en, m_master};
            2'd1: m_rd = {2'b00, m_flg};
            2'd2: m_rd = {1'b0, m_sflg, 1'b0, m_sen};
            default: m_rd = 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_vec();
        m_vec = m_req ? 8'(4 * (m_gidx + 1)) : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: advance model at the edge, compare 1 ns later, release pulses
    task automatic cyc();
        logic [5:0] pend;
        int w;
        logic fire, mfs;
        @(posedge clk);
        pend = m_flg & m_en & {6{m_master}};
        w    = winner(pend);
        fire = b_ack && m_req;
        mfs  = |(b_sub & m_sen);
        if (b_wr && b_sel == 2'd1) m_flg = b_wdata[5:0];
        if (fire) m_flg[m_gidx] = 1'b0;
        m_flg = m_flg | {mfs, b_evt};
        if (b_wr && b_sel == 2'd0) begin
            m_master = b_wdata[0];
            m_en     = b_wdata[6:1];
        end
        if (fire) m_master = 1'b0;
        if (b_wr && b_sel == 2'd2) begin
            m_sen  = b_wdata[2:0];
            m_sflg = b_wdata[6:4];
        end
        m_sflg = m_sflg | b_sub;
        if (!m_req) begin
            if (w >= 0) begin m_req = 1'b1; m_gidx = w; end
        end else if (b_ack) begin
            m_req = 1'b0;
        end else if (w < 0) begin
            m_req = 1'b0;
        end else begin
            m_gidx = w;
        end
        #1;
        chk("R3 irq_req", {7'd0, irq_req}, {7'd0, m_req});
        chk("R4 irq_vec", irq_vec, m_vec());
        chk("R10 reg_rdata", reg_rdata, m_rd(b_sel));
        b_evt = '0; b_sub = '0; b_wr = 1'b0; b_ack = 1'b0;
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        b_wr = 1'b1; b_sel = s; b_wdata = d;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk("R1 irq_req", {7'd0, irq_req}, 8'h00);
        chk("R1 irq_vec", irq_vec, 8'h00);
        for (int s = 0; s < 4; s++) begin
            b_sel = 2'(s);
            #1 chk("R1 reg_rdata", reg_rdata, 8'h00);
        end

        // R2: disabled source still latches, no request
        b_evt[4] = 1'b1; b_sel = 2'd1;
        cyc();
        chk("R2 uart flag latched", reg_rdata, 8'h10);
        chk("R2 no req while disabled", {7'd0, irq_req}, 8'h00);

        // R3/R4: enabling a pending flag raises the request two edges on
        wr(2'd0, 8'h21);
        cyc();
        chk("R3 req not yet", {7'd0, irq_req}, 8'h00);
        b_sel = 2'd1;
        cyc();
        chk("R3 req raised", {7'd0, irq_req}, 8'h01);
        chk("R4 uart vector", irq_vec, 8'h14);

        // R4: higher priority takes over, R5: acknowledge
        wr(2'd0, 8'h7F); b_evt = 5'b00110;
        cyc();
        b_sel = 2'd1;
        cyc();
        chk("R4 ext1 vector", irq_vec, 8'h08);
        b_ack = 1'b1;
        cyc();
        chk("R5 req dropped", {7'd0, irq_req}, 8'h00);
        chk("R5 ext1 flag cleared", reg_rdata, 8'h14);
        b_sel = 2'd0;
        #1 chk("R5 master cleared", reg_rdata, 8'h7E);

        // R6: write and event on the same flag
        wr(2'd1, 8'h00); b_evt[0] = 1'b1;
        cyc();
        chk("R6 hw set wins", reg_rdata, 8'h01);
        wr(2'd1, 8'h00);
        cyc();
        chk("R6 write clears", reg_rdata, 8'h00);

        // R7: sub-enable gates the combined flag
        wr(2'd2, 8'h01);
        cyc();
        b_sub = 3'b100;
        cyc();
        chk("R7 rtc subflag bit6", reg_rdata, 8'h41);
        b_sel = 2'd1;
        #1 chk("R7 disabled sub no main", reg_rdata, 8'h00);
        b_sub = 3'b001; b_sel = 2'd2;
        cyc();
        chk("R7 tmr2 subflag bit4", reg_rdata, 8'h51);
        b_sel = 2'd1;
        #1 chk("R7 combined flag set", reg_rdata, 8'h20);

        // R8: acknowledge of combined source keeps sub-flags
        wr(2'd0, 8'h41);
        cyc();
        cyc();
        chk("R4 combined vector", irq_vec, 8'h18);
        b_ack = 1'b1; b_sel = 2'd2;
        cyc();
        chk("R8 subflags kept", reg_rdata, 8'h51);
        b_sel = 2'd1;
        #1 chk("R5 combined flag cleared", reg_rdata, 8'h00);
        wr(2'd2, 8'h01);
        cyc();
        chk("R8 software clears subflags", reg_rdata, 8'h01);

        // R9: withdrawing the enable drops the request
        b_evt[0] = 1'b1;
        cyc();
        wr(2'd0, 8'h03);
        cyc();
        cyc();
        chk("R9 req up", {7'd0, irq_req}, 8'h01);
        chk("R4 ext0 vector", irq_vec, 8'h04);
        wr(2'd0, 8'h01);
        cyc();
        chk("R9 req still up", {7'd0, irq_req}, 8'h01);
        cyc();
        chk("R9 req withdrawn", {7'd0, irq_req}, 8'h00);

        // R5: acknowledge with no request has no effect
        b_ack = 1'b1; b_sel = 2'd0;
        cyc();
        chk("R5 idle ack ignored", reg_rdata, 8'h01);

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            b_evt   = 5'($urandom) & 5'($urandom) & 5'($urandom);
            b_sub   = 3'($urandom) & 3'($urandom) & 3'($urandom);
            b_wr    = ($urandom % 5) == 0;
            b_sel   = 2'($urandom);
            b_wdata = 8'($urandom);
            if (b_sel == 2'd0 && ($urandom % 4) != 0) b_wdata[0] = 1'b1;
            b_ack   = ($urandom % 3) == 0;
            cyc();
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule